// File: doc/BRIEF.md
# Frame Admission Gate with Descriptor Capture

This block sits between a camera pixel stream and a large data queue held in external memory. It keeps a running count of the free words in that queue. At the start of each frame it decides whether the whole frame will fit. An admitted frame has its pixel words passed on to the queue. A refused frame is discarded completely, so the data queue never holds a partial image.

The incoming stream carries a frame-active flag, a line-active flag and a per-word valid qualifier. Only words that have all three set are treated as pixels. The flags themselves are never forwarded.

While a frame streams in, the block measures its size. The width is the pixel count of the last line and the height is the number of lines. It also takes a snapshot of a free-running timestamp when the frame opens. When an admitted frame closes, it pushes a descriptor into a small internal queue. The descriptor holds the width, height, timestamp, frame number and a user metadata word, and downstream logic reads the descriptors in order.

Top module: `adm_frame_gate`

## Requirements
- R1: After reset, `wr_valid` and `desc_valid` are low, `drop_count` is zero, and `free_words` equals CAP_WORDS.
- R2: A word is forwarded on `wr_data`/`wr_valid` one cycle after it is presented, and only when `px_valid`, `frame_act` and `line_act` are all high in an admitted frame. Words with `line_act` low are never forwarded, and the data value is passed through unchanged.
- R3: `free_words` equals CAP_WORDS, minus the number of `mem_wr_pulse` cycles, plus the number of `mem_rd_pulse` cycles. It never exceeds CAP_WORDS.
- R4: For the first frame after reset, the frame is admitted only if `free_words` is at least `cfg_first_size` in the cycle where `frame_act` rises.
- R5: For every later frame, the frame is admitted only if `free_words` is at least the pixel count of the previous frame. The previous frame counts whether it was admitted or dropped, and equality admits.
- R6: A dropped frame forwards no words and pushes no descriptor, and `drop_count` increments by one. In any cycle, at most one of `drop_count` and the frame number advances.
- R7: If the descriptor queue already holds DESC_DEPTH entries when `frame_act` rises, the frame is dropped.
- R8: One cycle after `frame_act` falls on an admitted frame, a descriptor is available. Its `desc_width` is the pixel count of the frame's last line and its `desc_height` is the number of lines. Descriptors leave the queue in arrival order, one per cycle in which `desc_pop` is high.
- R9: `desc_ts` is the value of a 64-bit counter that is zero at reset and advances every clocked cycle. It is sampled in the cycle where `frame_act` rises.
- R10: `desc_num` is the count of frames admitted before this one, starting at 0. `desc_meta` is `cfg_meta` sampled in the cycle where `frame_act` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| px_valid | input | 1 | Word qualifier on the input stream |
| px_data | input | PIX_W | Input pixel word |
| frame_act | input | 1 | High for the duration of a frame |
| line_act | input | 1 | High for the duration of a line |
| cfg_first_size | input | S_W | Expected word count of the first frame after reset |
| cfg_meta | input | META_W | User metadata, sampled at frame start |
| mem_wr_pulse | input | 1 | One word entered the data queue |
| mem_rd_pulse | input | 1 | One word left the data queue |
| wr_valid | output | 1 | Forwarded pixel word is valid |
| wr_data | output | PIX_W | Forwarded pixel word |
| free_words | output | FREE_W | Current free-space estimate |
| drop_count | output | 32 | Number of refused frames |
| desc_valid | output | 1 | Descriptor queue is not empty |
| desc_pop | input | 1 | Remove the head descriptor |
| desc_width | output | X_W | Head descriptor: pixels in last line |
| desc_height | output | Y_W | Head descriptor: number of lines |
| desc_ts | output | 64 | Head descriptor: start-of-frame timestamp |
| desc_num | output | 32 | Head descriptor: frame number |
| desc_meta | output | META_W | Head descriptor: user metadata |

## Verification
The bench pushes the free space down to exactly zero and then back up to exactly the needed size. A design with an off-by-one in the fit comparison would then drop the equal case or admit the frame one word short.

One frame arrives while the descriptor queue is full. A gate that ignored the full queue would forward that frame's words with no matching descriptor.

The bench also checks that a dropped frame's size still sets the next requirement, and that the reset-time first-size setting is used only once. A design that measured only admitted frames, or that kept using the first-size value, would make the wrong decision on the frames that follow.

Every line carries an idle word inside it and a valid-qualified word outside it. A design that leaked the sync qualifiers would show a wrong word count and a wrong data sum.

// File: rtl/adm_pkg.sv
package adm_pkg;
   localparam int TS_W  = 64;
   localparam int NUM_W = 32;
   typedef logic [TS_W-1:0]  stamp_t;
   typedef logic [NUM_W-1:0] fnum_t;
endpackage

// File: rtl/adm_space_tracker.sv
module adm_space_tracker #(
   parameter int CAP_WORDS = 64,
   parameter int FREE_W    = $clog2(CAP_WORDS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_pulse,
   input  logic              rd_pulse,
   output logic [FREE_W-1:0] free_w
);
   localparam logic [FREE_W-1:0] CAP_V = FREE_W'(CAP_WORDS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) free_w <= CAP_V;
      else        free_w <= free_w - FREE_W'(wr_pulse) + FREE_W'(rd_pulse);
   end

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      free_w <= CAP_V);
endmodule

// File: rtl/adm_res_meter.sv
module adm_res_meter #(
   parameter int X_W = 12,
   parameter int Y_W = 12,
   parameter int S_W = 24
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           frame_rise,
   input  logic           in_frame,
   input  logic           pix,
   input  logic           line_act,
   output logic [X_W-1:0] width_now,
   output logic [Y_W-1:0] height_now,
   output logic [S_W-1:0] words_now
);
   logic           line_q;
   logic [X_W-1:0] cur_w, width_q;
   logic [Y_W-1:0] lines_q;
   logic [S_W-1:0] words_q;
   logic           line_end;

   assign line_end = line_q & ~line_act & in_frame;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q  <= 1'b0;
         cur_w   <= '0;
         width_q <= '0;
         lines_q <= '0;
         words_q <= '0;
      end else begin
         line_q <= line_act;
         if (frame_rise) begin
            cur_w   <= X_W'(pix);
            width_q <= '0;
            lines_q <= '0;
            words_q <= S_W'(pix);
         end else begin
            words_q <= words_q + S_W'(pix);
            cur_w   <= line_end ? '0 : cur_w + X_W'(pix);
            if (line_end) begin
               width_q <= cur_w;
               lines_q <= lines_q + 1'b1;
            end
         end
      end
   end

   // values as they stand including a line closing in this cycle
   assign width_now  = line_end ? cur_w : width_q;
   assign height_now = lines_q + Y_W'(line_end);
   assign words_now  = words_q;
endmodule

// File: rtl/adm_desc_fifo.sv
module adm_desc_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic          full,
   output logic          not_empty,
   output logic [DW-1:0] head
);
   localparam int CW = $clog2(DEPTH + 1);
   logic [CW-1:0] count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= count + CW'(push) - CW'(pop & not_empty);
   end

   assign full      = (count == CW'(DEPTH));
   assign not_empty = (count != '0);

   generate
      if (DEPTH == 1) begin : g_single
         logic [DW-1:0] slot;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    slot <= '0;
            else if (push) slot <= push_data;
         end
         assign head = slot;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         logic [DW-1:0] mem [DEPTH];
         logic [PW-1:0] wp, rp;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wp <= '0;
               rp <= '0;
            end else begin
               if (push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
               if (pop && not_empty) rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
            end
         end
         always_ff @(posedge clk) begin
            if (push) mem[wp] <= push_data;
         end
         assign head = mem[rp];
      end
   endgenerate

   // R7
   push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
endmodule

// File: rtl/adm_frame_gate.sv
module adm_frame_gate
   import adm_pkg::*;
#(
   parameter int CAP_WORDS  = 1 << 20,
   parameter int MAX_WIDTH  = 4095,
   parameter int MAX_LINES  = 4095,
   parameter int DESC_DEPTH = 4,
   parameter int PIX_W      = 16,
   parameter int META_W     = 16,
   localparam int FREE_W    = $clog2(CAP_WORDS + 1),
   localparam int X_W       = $clog2(MAX_WIDTH + 1),
   localparam int Y_W       = $clog2(MAX_LINES + 1),
   localparam int S_W       = X_W + Y_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              px_valid,
   input  logic [PIX_W-1:0]  px_data,
   input  logic              frame_act,
   input  logic              line_act,
   input  logic [S_W-1:0]    cfg_first_size,
   input  logic [META_W-1:0] cfg_meta,
   input  logic              mem_wr_pulse,
   input  logic              mem_rd_pulse,
   output logic              wr_valid,
   output logic [PIX_W-1:0]  wr_data,
   output logic [FREE_W-1:0] free_words,
   output logic [31:0]       drop_count,
   output logic              desc_valid,
   input  logic              desc_pop,
   output logic [X_W-1:0]    desc_width,
   output logic [Y_W-1:0]    desc_height,
   output logic [63:0]       desc_ts,
   output logic [31:0]       desc_num,
   output logic [META_W-1:0] desc_meta
);
   localparam int CMP_W = (FREE_W > S_W) ? FREE_W : S_W;
   localparam int DW    = X_W + Y_W + TS_W + NUM_W + META_W;

   generate
      if (CAP_WORDS < 1 || DESC_DEPTH < 1 || PIX_W < 1 || META_W < 1) begin : g_bad_cfg
         $error("adm_frame_gate: parameters out of range");
      end
   endgenerate

   logic frame_q, rise, fall, pix, keep, admit_now, fit, seen_q, adm_q;
   logic [S_W-1:0]    last_q, need, words_now;
   logic [X_W-1:0]    width_now;
   logic [Y_W-1:0]    height_now;
   stamp_t            ts_q, ts_lat;
   fnum_t             fnum_q, num_lat;
   logic [META_W-1:0] meta_lat;
   logic              d_full, push;
   logic [DW-1:0]     d_head;

   assign rise = frame_act & ~frame_q;
   assign fall = ~frame_act & frame_q;
   assign pix  = px_valid & frame_act & line_act;

   adm_space_tracker #(.CAP_WORDS(CAP_WORDS), .FREE_W(FREE_W)) u_space (
      .clk(clk), .rst_n(rst_n), .wr_pulse(mem_wr_pulse),
      .rd_pulse(mem_rd_pulse), .free_w(free_words));

   adm_res_meter #(.X_W(X_W), .Y_W(Y_W), .S_W(S_W)) u_meter (
      .clk(clk), .rst_n(rst_n), .frame_rise(rise),
      .in_frame(frame_act | frame_q), .pix(pix), .line_act(line_act),
      .width_now(width_now), .height_now(height_now), .words_now(words_now));

   // fit test: last measured frame size, or the configured size before any frame
   assign need      = seen_q ? last_q : cfg_first_size;
   assign fit       = CMP_W'(free_words) >= CMP_W'(need);
   assign admit_now = fit & ~d_full;
   assign keep      = rise ? admit_now : adm_q;
   assign push      = fall & adm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q    <= 1'b0;
         adm_q      <= 1'b0;
         seen_q     <= 1'b0;
         last_q     <= '0;
         ts_q       <= '0;
         ts_lat     <= '0;
         fnum_q     <= '0;
         num_lat    <= '0;
         meta_lat   <= '0;
         drop_count <= '0;
         wr_valid   <= 1'b0;
         wr_data    <= '0;
      end else begin
         frame_q  <= frame_act;
         ts_q     <= ts_q + 1'b1;
         wr_valid <= pix & keep;
         wr_data  <= px_data;
         if (rise) begin
            adm_q    <= admit_now;
            ts_lat   <= ts_q;
            meta_lat <= cfg_meta;
            num_lat  <= fnum_q;
            if (admit_now) fnum_q     <= fnum_q + 1'b1;
            else           drop_count <= drop_count + 1'b1;
         end else if (fall) begin
            adm_q  <= 1'b0;
            last_q <= words_now;
            seen_q <= 1'b1;
         end
      end
   end

   adm_desc_fifo #(.DW(DW), .DEPTH(DESC_DEPTH)) u_desc (
      .clk(clk), .rst_n(rst_n), .push(push),
      .push_data({width_now, height_now, ts_lat, num_lat, meta_lat}),
      .pop(desc_pop), .full(d_full), .not_empty(desc_valid), .head(d_head));

   assign {desc_width, desc_height, desc_ts, desc_num, desc_meta} = d_head;

   // R2
   strip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> $past(line_act && frame_act));
   // R6
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_count != $past(drop_count)) |-> (fnum_q == $past(fnum_q)));
   // R9
   stamp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (ts_lat < ts_q));
endmodule

// File: tb/test_adm_frame_gate.sv
module test_adm_frame_gate;
   localparam int CAP = 64;
   localparam int X_W = 4;
   localparam int Y_W = 4;
   localparam int S_W = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic px_valid = 0, frame_act = 0, line_act = 0, mem_rd_pulse = 0, desc_pop = 0;
   logic [7:0]  px_data = '0;
   logic [S_W-1:0] cfg_first_size = '0;
   logic [15:0] cfg_meta = '0;
   logic mem_wr_pulse, wr_valid, desc_valid;
   logic [7:0]  wr_data;
   logic [6:0]  free_words;
   logic [31:0] drop_count, desc_num;
   logic [X_W-1:0] desc_width;
   logic [Y_W-1:0] desc_height;
   logic [63:0] desc_ts;
   logic [15:0] desc_meta;

   int nchk = 0, nfail = 0;
   int mon_cnt = 0, mon_sum = 0;
   logic [63:0] cyc;

   always #2.5 clk = ~clk;

   assign mem_wr_pulse = wr_valid;

   adm_frame_gate #(.CAP_WORDS(CAP), .MAX_WIDTH(15), .MAX_LINES(15),
                    .DESC_DEPTH(2), .PIX_W(8), .META_W(16)) i_adm_frame_gate (
      .clk(clk), .rst_n(rst_n), .px_valid(px_valid), .px_data(px_data),
      .frame_act(frame_act), .line_act(line_act), .cfg_first_size(cfg_first_size),
      .cfg_meta(cfg_meta), .mem_wr_pulse(mem_wr_pulse), .mem_rd_pulse(mem_rd_pulse),
      .wr_valid(wr_valid), .wr_data(wr_data), .free_words(free_words),
      .drop_count(drop_count), .desc_valid(desc_valid), .desc_pop(desc_pop),
      .desc_width(desc_width), .desc_height(desc_height), .desc_ts(desc_ts),
      .desc_num(desc_num), .desc_meta(desc_meta));

   // independent timestamp model: cycles since reset release
   always @(posedge clk) begin
      if (!rst_n) cyc <= '0;
      else        cyc <= cyc + 1;
   end

   always @(negedge clk) begin
      if (wr_valid) begin
         mon_cnt = mon_cnt + 1;
         mon_sum = mon_sum + int'(wr_data);
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input int first);
      @(negedge clk);
      rst_n = 1'b0;
      cfg_first_size = S_W'(first);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // sends one frame of w x h pixels and checks the forwarded words
   task automatic send_frame(input int w, input int h, input logic [15:0] meta,
                             input bit adm, output longint ts_exp);
      int c0, s0, esum;
      c0 = mon_cnt; s0 = mon_sum; esum = 0;
      @(negedge clk);
      frame_act = 1'b1; cfg_meta = meta; ts_exp = longint'(cyc);
      for (int l = 0; l < h; l++) begin
         for (int p = 0; p < w; p++) begin
            @(negedge clk);
            line_act = 1'b1; px_valid = 1'b1; px_data = 8'(l * 16 + p + 1);
            esum += l * 16 + p + 1;
            if (p == 0) begin
               @(negedge clk);
               px_valid = 1'b0;
            end
         end
         @(negedge clk);
         line_act = 1'b0; px_valid = 1'b1; px_data = 8'hFF;
      end
      @(negedge clk);
      px_valid = 1'b0; frame_act = 1'b0;
      repeat (4) @(negedge clk);
      // R2 only qualified pixel words, unchanged, in admitted frames
      chk(mon_cnt - c0 == (adm ? w * h : 0), "R2/R6 word count", mon_cnt - c0, adm ? w * h : 0);
      chk(mon_sum - s0 == (adm ? esum : 0), "R2 data sum", mon_sum - s0, adm ? esum : 0);
   endtask

   task automatic check_desc(input int w, input int h, input longint ts, input int num,
                             input logic [15:0] meta, input bit pop);
      chk(desc_valid == 1'b1, "R8 desc valid", desc_valid, 1);
      chk(desc_width == X_W'(w), "R8 width", desc_width, w);
      chk(desc_height == Y_W'(h), "R8 height", desc_height, h);
      chk(desc_ts == 64'(ts), "R9 timestamp", desc_ts, ts);
      chk(desc_num == 32'(num), "R10 frame number", desc_num, num);
      chk(desc_meta == meta, "R10 meta", desc_meta, meta);
      if (pop) begin
         desc_pop = 1'b1;
         @(negedge clk);
         desc_pop = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic drain(input int n);
      for (int i = 0; i < n; i++) begin
         mem_rd_pulse = 1'b1;
         @(negedge clk);
      end
      mem_rd_pulse = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset;
      do_reset(20);
      chk(wr_valid == 0, "R1 wr_valid", wr_valid, 0);
      chk(desc_valid == 0, "R1 desc_valid", desc_valid, 0);
      chk(drop_count == 0, "R1 drop_count", drop_count, 0);
      chk(free_words == 7'(CAP), "R1 free_words", free_words, CAP);
   endtask

   task automatic t_fill_and_full;
      longint ta, tb, tc;
      send_frame(4, 3, 16'hA1, 1, ta);                      // R4 first frame, 20 <= 64
      chk(free_words == 52, "R3 free after A", free_words, 52);
      check_desc(4, 3, ta, 0, 16'hA1, 0);
      send_frame(5, 2, 16'hB2, 1, tb);                      // R5 need 12
      chk(free_words == 42, "R3 free after B", free_words, 42);
      send_frame(3, 1, 16'hC3, 0, tc);                      // R7 queue full
      chk(drop_count == 1, "R7 drop on full queue", drop_count, 1);
      check_desc(4, 3, ta, 0, 16'hA1, 1);
      check_desc(5, 2, tb, 1, 16'hB2, 1);
      chk(desc_valid == 0, "R7 no descriptor for dropped frame", desc_valid, 0);
   endtask

   task automatic t_space_limits;
      longint td, te, tf, tg, th;
      send_frame(6, 7, 16'hD4, 1, td);                      // R5 need 3 from dropped frame
      chk(free_words == 0, "R3 free empty", free_words, 0);
      check_desc(6, 7, td, 2, 16'hD4, 1);
      send_frame(2, 2, 16'hE5, 0, te);                      // R5 need 42 > 0
      chk(drop_count == 2, "R6 drop count", drop_count, 2);
      chk(desc_valid == 0, "R6 no descriptor", desc_valid, 0);
      drain(42);
      chk(free_words == 42, "R3 free after reads", free_words, 42);
      send_frame(6, 7, 16'hF6, 1, tf);                      // R5 need 4
      check_desc(6, 7, tf, 3, 16'hF6, 1);
      drain(42);
      send_frame(7, 6, 16'h17, 1, tg);                      // R5 equality admits
      chk(free_words == 0, "R5 equal fit admitted", free_words, 0);
      check_desc(7, 6, tg, 4, 16'h17, 1);
      drain(41);
      send_frame(7, 6, 16'h28, 0, th);                      // R5 one word short
      chk(drop_count == 3, "R5 one short dropped", drop_count, 3);
      chk(free_words == 41, "R3 free unchanged by drop", free_words, 41);
   endtask

   task automatic t_first_size;
      longint t1, t2;
      do_reset(65);
      send_frame(1, 2, 16'h39, 0, t1);                      // R4 65 > 64
      chk(drop_count == 1, "R4 first frame dropped", drop_count, 1);
      send_frame(2, 2, 16'h4A, 1, t2);                      // R5 need 2 from dropped frame
      chk(drop_count == 1, "R5 second admitted", drop_count, 1);
      check_desc(2, 2, t2, 0, 16'h4A, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      t_reset();
      t_fill_and_full();
      t_space_limits();
      t_first_size();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule